// File: doc/BRIEF.md
# Code Puncture and Depuncture Unit

This block thins and restores the bit stream of a convolutional code according to a fixed puncture pattern given as a parameter. The pattern is an N-position mask; a one keeps the position and a zero removes it. K, the number of ones in the mask, sets the width of the thinned word.

It has two independent channels, each with its own valid flag. The thinning channel takes an N-bit coded word and returns the K kept bits packed together. The restoring channel runs in the other direction. It takes K soft-decision symbols of W bits each, puts a neutral erasure value into every removed position, and returns an N-symbol word that a soft-decision Viterbi decoder can read directly. Both channels register their result once, so output data and output valid appear one cycle after the input.

Top module: `punct_codec`

## Requirements
- R1: The thinning output is K bits wide, where K is the number of ones in the pattern. The restoring input is K*W bits wide and the restoring output is N*W bits wide.
- R2: In the thinning result, output bit K-1 carries the input bit at the highest pattern position that holds a one. Each lower output bit carries the input bit at the next lower such position. Input bits at zero positions are dropped.
- R3: In the restoring result, the symbol field p*W +: W of every pattern position p that holds zero equals the ERASE parameter (default 3'b100).
- R4: In the restoring result, input symbol K-1 (the most significant W-bit field) goes to the highest pattern position that holds a one. Each lower input symbol goes to the next lower such position.
- R5: Each channel's output valid is high exactly in the cycle after a clock edge at which its input valid was high, and its output data is the result for that input.
- R6: When a channel's input valid is low at a clock edge, that channel's output data keeps its previous value, whatever its input data is.
- R7: While reset (rst_n low) is active, both output valids and both output data words are zero.
- R8: With a pattern of all ones, both channels pass their input through unchanged.
- R9: With a pattern holding a single one, the thinning output is that one input bit. The restoring output is the erasure value at every position except that one, which carries the input symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| punc_vld_i | input | 1 | Thinning input valid |
| punc_bits_i | input | N | Coded word to be thinned |
| punc_vld_o | output | 1 | Thinning output valid |
| punc_bits_o | output | K | Kept bits, packed |
| dep_vld_i | input | 1 | Restoring input valid |
| dep_syms_i | input | K*W | Surviving soft symbols |
| dep_vld_o | output | 1 | Restoring output valid |
| dep_syms_o | output | N*W | Full-length soft word with erasures |

## Verification
The checker verifies on every cycle that each valid flag trails its input valid by one cycle, that idle cycles leave the output data unchanged, and that every removed position in the restored word holds the erasure value. Only the bench's scenarios can show that kept bits and symbols land in the right slots and order. The same holds for the reset values and for the behaviour of the single-one and all-ones patterns, which it exercises on separate instances.

// File: rtl/punct_codec.sv
module punct_codec #(
  parameter int             N     = 8,
  parameter logic [N-1:0]   PAT   = 8'b1101_0110,
  parameter int             W     = 3,
  parameter logic [W-1:0]   ERASE = 3'b100,
  localparam int            K     = $countones(PAT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             punc_vld_i,
  input  logic [N-1:0]     punc_bits_i,
  output logic             punc_vld_o,
  output logic [K-1:0]     punc_bits_o,
  input  logic             dep_vld_i,
  input  logic [K*W-1:0]   dep_syms_i,
  output logic             dep_vld_o,
  output logic [N*W-1:0]   dep_syms_o
);

  // pattern position of the slot-th kept entry, counted from the top
  function automatic int src_pos(int slot);
    int seen;
    seen = 0;
    src_pos = 0;
    for (int p = N - 1; p >= 0; p--)
      if (PAT[p]) begin
        if (seen == slot) src_pos = p;
        seen++;
      end
  endfunction

  // number of kept positions above pos
  function automatic int rank_of(int pos);
    rank_of = 0;
    for (int p = N - 1; p > pos; p--)
      if (PAT[p]) rank_of++;
  endfunction

  logic [K-1:0]   punc_nxt;
  logic [N*W-1:0] dep_nxt;

  for (genvar j = 0; j < K; j++) begin : g_pack
    localparam int SRC = src_pos(j);
    assign punc_nxt[K-1-j] = punc_bits_i[SRC];
  end

  for (genvar p = 0; p < N; p++) begin : g_fill
    if (PAT[p]) begin : g_keep
      localparam int SLOT = K - 1 - rank_of(p);
      assign dep_nxt[p*W +: W] = dep_syms_i[SLOT*W +: W];
    end else begin : g_hole
      assign dep_nxt[p*W +: W] = ERASE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      punc_vld_o  <= 1'b0;
      punc_bits_o <= '0;
      dep_vld_o   <= 1'b0;
      dep_syms_o  <= '0;
    end else begin
      punc_vld_o <= punc_vld_i;
      dep_vld_o  <= dep_vld_i;
      if (punc_vld_i) punc_bits_o <= punc_nxt;
      if (dep_vld_i)  dep_syms_o  <= dep_nxt;
    end
  end

endmodule

module punct_codec_chk #(
  parameter int           N     = 8,
  parameter logic [N-1:0] PAT   = 8'b1101_0110,
  parameter int           W     = 3,
  parameter logic [W-1:0] ERASE = 3'b100,
  parameter int           K     = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           punc_vld_i,
  input logic           punc_vld_o,
  input logic [K-1:0]   punc_bits_o,
  input logic           dep_vld_i,
  input logic           dep_vld_o,
  input logic [N*W-1:0] dep_syms_o
);

  a_r5_punc_valid: assert property (@(posedge clk) disable iff (!rst_n)
    punc_vld_i |=> punc_vld_o);
  a_r5_punc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !punc_vld_i |=> !punc_vld_o);
  a_r5_dep_valid: assert property (@(posedge clk) disable iff (!rst_n)
    dep_vld_i |=> dep_vld_o);
  a_r5_dep_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dep_vld_i |=> !dep_vld_o);
  a_r6_punc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !punc_vld_i |=> $stable(punc_bits_o));
  a_r6_dep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dep_vld_i |=> $stable(dep_syms_o));

  for (genvar p = 0; p < N; p++) begin : g_hole
    if (!PAT[p]) begin : g_chk
      a_r3_erase: assert property (@(posedge clk) disable iff (!rst_n)
        dep_vld_o |-> dep_syms_o[p*W +: W] == ERASE);
    end
  end

endmodule

bind punct_codec punct_codec_chk #(.N(N), .PAT(PAT), .W(W), .ERASE(ERASE), .K(K)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .punc_vld_i(punc_vld_i), .punc_vld_o(punc_vld_o), .punc_bits_o(punc_bits_o),
  .dep_vld_i(dep_vld_i), .dep_vld_o(dep_vld_o), .dep_syms_o(dep_syms_o)
);

// File: tb/punct_codec_tb.sv
`timescale 1ns/1ps
module punct_codec_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // main instance: pattern 1101_0110, K=5, W=3, erase 3'b100
  logic        pv_i, pv_o, dv_i, dv_o;
  logic [7:0]  pb_i;
  logic [4:0]  pb_o;
  logic [14:0] ds_i;
  logic [23:0] ds_o;

  punct_codec u_dut (
    .clk(clk), .rst_n(rst_n),
    .punc_vld_i(pv_i), .punc_bits_i(pb_i), .punc_vld_o(pv_o), .punc_bits_o(pb_o),
    .dep_vld_i(dv_i), .dep_syms_i(ds_i), .dep_vld_o(dv_o), .dep_syms_o(ds_o)
  );

  // single-one instance: pattern 0100
  logic        p1v_i, p1v_o, d1v_i, d1v_o;
  logic [3:0]  p1b_i;
  logic [0:0]  p1b_o;
  logic [2:0]  d1s_i;
  logic [11:0] d1s_o;

  punct_codec #(.N(4), .PAT(4'b0100)) u_dut_one (
    .clk(clk), .rst_n(rst_n),
    .punc_vld_i(p1v_i), .punc_bits_i(p1b_i), .punc_vld_o(p1v_o), .punc_bits_o(p1b_o),
    .dep_vld_i(d1v_i), .dep_syms_i(d1s_i), .dep_vld_o(d1v_o), .dep_syms_o(d1s_o)
  );

  // all-ones instance: pattern 1111
  logic        pav_i, pav_o, dav_i, dav_o;
  logic [3:0]  pab_i, pab_o;
  logic [11:0] das_i, das_o;

  punct_codec #(.N(4), .PAT(4'b1111)) u_dut_all (
    .clk(clk), .rst_n(rst_n),
    .punc_vld_i(pav_i), .punc_bits_i(pab_i), .punc_vld_o(pav_o), .punc_bits_o(pab_o),
    .dep_vld_i(dav_i), .dep_syms_i(das_i), .dep_vld_o(dav_o), .dep_syms_o(das_o)
  );

  localparam int NV = 5;
  localparam logic [7:0] P_IN [NV] = '{8'hFF, 8'h00, 8'b1010_1010, 8'b0101_0110, 8'b1000_1001};
  localparam logic [4:0] P_EXP[NV] = '{5'b11111, 5'b00000, 5'b10001, 5'b01111, 5'b10000};
  localparam int ND = 3;
  localparam logic [14:0] D_IN [ND] = '{
    {3'd1, 3'd2, 3'd3, 3'd5, 3'd6},
    {3'd7, 3'd7, 3'd7, 3'd7, 3'd7},
    15'd0};
  localparam logic [23:0] D_EXP[ND] = '{
    {3'd1, 3'd2, 3'd4, 3'd3, 3'd4, 3'd5, 3'd6, 3'd4},
    {3'd7, 3'd7, 3'd4, 3'd7, 3'd4, 3'd7, 3'd7, 3'd4},
    {3'd0, 3'd0, 3'd4, 3'd0, 3'd4, 3'd0, 3'd0, 3'd4}};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_all;
    pv_i = 0; dv_i = 0; p1v_i = 0; d1v_i = 0; pav_i = 0; dav_i = 0;
  endtask

  initial begin
    idle_all();
    pb_i = 8'hA5; ds_i = '1; p1b_i = '1; d1s_i = '1; pab_i = '1; das_i = '1;
    pv_i = 1; dv_i = 1;
    step(); step();
    // R7: reset holds outputs at zero even with valid inputs
    check("R7", {pv_o, dv_o, p1v_o, pav_o}, 0);
    check("R7", pb_o, 0);
    check("R7", ds_o, 0);
    // R1: port widths
    check("R1", $bits(pb_o), 5);
    check("R1", $bits(ds_i), 15);
    check("R1", $bits(ds_o), 24);
    @(negedge clk);
    rst_n = 1; idle_all();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pv_i = 1; pb_i = P_IN[i];
      if (i < ND) begin dv_i = 1; ds_i = D_IN[i]; end else dv_i = 0;
      step();
      check("R5", pv_o, 1);
      check("R2", pb_o, P_EXP[i]);
      if (i < ND) begin
        check("R5", dv_o, 1);
        check("R3 R4", ds_o, D_EXP[i]);
      end
    end

    // R6: idle cycle with changed data keeps outputs
    @(negedge clk);
    pv_i = 0; dv_i = 0; pb_i = 8'h3C; ds_i = 15'h1234;
    step();
    check("R5", {pv_o, dv_o}, 0);
    check("R6", pb_o, P_EXP[NV-1]);
    check("R6", ds_o, D_EXP[ND-1]);

    // R9: single-one pattern
    @(negedge clk);
    p1v_i = 1; p1b_i = 4'b0100; d1v_i = 1; d1s_i = 3'd5;
    step();
    check("R9", p1b_o, 1);
    check("R9", d1s_o, {3'd4, 3'd5, 3'd4, 3'd4});
    @(negedge clk);
    p1b_i = 4'b1011;
    step();
    check("R9", p1b_o, 0);

    // R8: all-ones pattern passes through
    @(negedge clk);
    idle_all();
    pav_i = 1; pab_i = 4'b1001; dav_i = 1; das_i = {3'd1, 3'd2, 3'd3, 3'd5};
    step();
    check("R8", pab_o, 4'b1001);
    check("R8", das_o, {3'd1, 3'd2, 3'd3, 3'd5});
    check("R5", {pav_o, dav_o}, 2'b11);

    // R7: reset mid-run clears outputs
    @(negedge clk);
    idle_all();
    rst_n = 0;
    step();
    check("R7", {pv_o, dv_o}, 0);
    check("R7", pb_o, 0);
    check("R7", das_o, 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule